// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Hi/Lo Result Registers

This block multiplies or divides two operands over many cycles and keeps the outcome in a pair of dedicated result registers, Hi and Lo. One start command picks one of four operations: signed or unsigned multiply, or signed or unsigned divide. A multiply leaves the double-width product split across the pair. A divide leaves the quotient in Lo and the remainder in Hi.

The work runs one bit per cycle. Multiply uses shift-and-add on operand magnitudes. Divide uses restoring division on magnitudes. Signs are applied in a final write-back cycle. While the unit works it holds `busy` high and drops any further start command. A consumer that asks for Hi or Lo while the unit is busy gets a stall until the result is written. Both result registers are always visible on their read ports.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `hiData` and `loData` are zero and `busy` is low.
- R2: A start is accepted only while `busy` is low. `startOp` encodes 0 = signed multiply, 1 = unsigned multiply, 2 = signed divide, 3 = unsigned divide. `busy` then stays high for exactly WIDTH+1 cycles: WIDTH iteration cycles and one write-back cycle.
- R3: Unsigned multiply leaves the upper WIDTH bits of the unsigned product of `opA` and `opB` in Hi and the lower WIDTH bits in Lo.
- R4: Signed multiply does the same with the two's-complement product of the operands.
- R5: Unsigned divide leaves `opA / opB` in Lo and `opA mod opB` in Hi.
- R6: Signed divide truncates the quotient toward zero, and the remainder takes the sign of the dividend. The most negative value divided by -1 gives a quotient that wraps to the most negative value.
- R7: A start that arrives while `busy` is high is ignored. The running operation finishes on its own schedule with its own operands.
- R8: `readStall` is high exactly when `readHiReq` or `readLoReq` is high while `busy` is high. `hiData` and `loData` show the result in the same cycle that `busy` falls.
- R9: A divide by zero completes in the normal WIDTH+1 busy cycles and raises no error. The Hi/Lo values it leaves are not specified.
- R10: While idle, Hi and Lo keep their values whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start command |
| startOp | input | 2 | Operation select (see R2) |
| opA | input | WIDTH | First operand (multiplicand or dividend) |
| opB | input | WIDTH | Second operand (multiplier or divisor) |
| readHiReq | input | 1 | Consumer wants Hi |
| readLoReq | input | 1 | Consumer wants Lo |
| busy | output | 1 | Operation in progress |
| readStall | output | 1 | Read request must wait |
| hiData | output | WIDTH | Hi register contents |
| loData | output | WIDTH | Lo register contents |

## Verification
A read request can coincide with a start command, and a pending read can coincide with write-back. The bench raises `readHiReq` in the same cycle that it issues a start. It checks that `readStall` is low before the accepting edge and high right after it. It holds the request through the whole operation and checks that, in the cycle `busy` falls, the stall clears and `hiData` already carries the new result. All results are judged against arithmetic done in the bench on an 8-bit instance, swept over a grid of edge values and strided values for all four operations.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULS = 2'd0,
    OP_MULU = 2'd1,
    OP_DIVS = 2'd2,
    OP_DIVU = 2'd3
  } mdOpE;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } mdStrbT;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startValid,
  output logic   busy,
  output mdStrbT strb
);
  localparam int CW = $clog2(WIDTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} ctrlStateE;

  ctrlStateE state;
  logic [CW-1:0] iterCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      iterCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (startValid) begin
          state   <= S_RUN;
          iterCnt <= CW'(WIDTH);
        end
        S_RUN: begin
          iterCnt <= iterCnt - 1'b1;
          if (iterCnt == CW'(1)) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load   = (state == S_IDLE) && startValid;
    strb.step   = (state == S_RUN);
    strb.finish = (state == S_FIN);
  end

  assign busy = (state != S_IDLE);

  // R2: busy only rises because a start arrived
  p_start_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startValid));

  // R2: at most one strobe per cycle
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.step, strb.finish}));
endmodule

// File: rtl/muldiv_path.sv
module muldiv_path
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdStrbT           strb,
  input  logic [1:0]       startOp,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] hiReg,
  output logic [WIDTH-1:0] loReg
);
  localparam int W2 = 2 * WIDTH;

  logic             isDiv, negMain, negRem;
  logic [WIDTH-1:0] acc, mq, dvs;

  logic             isSigned, aNeg, bNeg;
  logic [WIDTH-1:0] magA, magB;
  logic [WIDTH:0]   mulSum, divShift, divDiff;
  logic             divFits;
  logic [W2-1:0]    prodRaw, prodFix;
  logic [WIDTH-1:0] quotFix, remFix;

  always_comb begin
    isSigned = (startOp == OP_MULS) || (startOp == OP_DIVS);
    aNeg     = isSigned && opA[WIDTH-1];
    bNeg     = isSigned && opB[WIDTH-1];
    magA     = aNeg ? (~opA + 1'b1) : opA;
    magB     = bNeg ? (~opB + 1'b1) : opB;

    mulSum   = {1'b0, acc} + (mq[0] ? {1'b0, dvs} : '0);
    divShift = {acc, mq[WIDTH-1]};
    divDiff  = divShift - {1'b0, dvs};
    divFits  = !divDiff[WIDTH];

    prodRaw  = {acc, mq};
    prodFix  = negMain ? (~prodRaw + 1'b1) : prodRaw;
    quotFix  = negMain ? (~mq + 1'b1) : mq;
    remFix   = negRem ? (~acc + 1'b1) : acc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isDiv   <= 1'b0;
      negMain <= 1'b0;
      negRem  <= 1'b0;
      acc     <= '0;
      mq      <= '0;
      dvs     <= '0;
      hiReg   <= '0;
      loReg   <= '0;
    end else if (strb.load) begin
      isDiv   <= startOp[1];
      negMain <= aNeg ^ bNeg;
      negRem  <= aNeg;
      acc     <= '0;
      mq      <= magA;
      dvs     <= magB;
    end else if (strb.step) begin
      if (isDiv) begin
        acc <= divFits ? divDiff[WIDTH-1:0] : divShift[WIDTH-1:0];
        mq  <= {mq[WIDTH-2:0], divFits};
      end else begin
        acc <= mulSum[WIDTH:1];
        mq  <= {mulSum[0], mq[WIDTH-1:1]};
      end
    end else if (strb.finish) begin
      hiReg <= isDiv ? remFix  : prodFix[W2-1:WIDTH];
      loReg <= isDiv ? quotFix : prodFix[WIDTH-1:0];
    end
  end

  // R5: the partial remainder stays below the divisor magnitude
  p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && isDiv && (dvs != '0)) |-> (acc < dvs));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [1:0]       startOp,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             readHiReq,
  input  logic             readLoReq,
  output logic             busy,
  output logic             readStall,
  output logic [WIDTH-1:0] hiData,
  output logic [WIDTH-1:0] loData
);
  mdStrbT strb;

  muldiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .busy(busy), .strb(strb)
  );

  muldiv_path #(.WIDTH(WIDTH)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .startOp(startOp),
    .opA(opA), .opB(opB), .hiReg(hiData), .loReg(loData)
  );

  assign readStall = busy && (readHiReq || readLoReq);

  localparam int BCW = $clog2(WIDTH + 2) + 1;
  logic [BCW-1:0] busyCnt;
  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else busyCnt <= '0;
  end

  // R2 and R9: every operation is busy for WIDTH+1 cycles
  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == BCW'(WIDTH + 1)));

  // R10: results hold while idle
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> ($stable(hiData) && $stable(loData)));
endmodule

// File: tb/muldiv_unit_test.sv
`timescale 1ns/1ps
module muldiv_unit_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startValid = 1'b0;
  logic [1:0]   startOp = 2'd0;
  logic [W-1:0] opA = '0, opB = '0;
  logic         readHiReq = 1'b0, readLoReq = 1'b0;
  logic         busy, readStall;
  logic [W-1:0] hiData, loData;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  muldiv_unit #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
    .opA(opA), .opB(opB), .readHiReq(readHiReq), .readLoReq(readLoReq),
    .busy(busy), .readStall(readStall), .hiData(hiData), .loData(loData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [1:0] op, input logic [W-1:0] a,
                                input logic [W-1:0] b,
                                output logic [W-1:0] eh, output logic [W-1:0] el);
    int sa, sb, ua, ub, p, q, r;
    sa = int'($signed(a));
    sb = int'($signed(b));
    ua = int'(a);
    ub = int'(b);
    case (op)
      2'd0: begin p = sa * sb; eh = p[2*W-1:W]; el = p[W-1:0]; end
      2'd1: begin p = ua * ub; eh = p[2*W-1:W]; el = p[W-1:0]; end
      2'd2: begin q = sa / sb; r = sa % sb; eh = r[W-1:0]; el = q[W-1:0]; end
      default: begin q = ua / ub; r = ua % ub; eh = r[W-1:0]; el = q[W-1:0]; end
    endcase
  endfunction

  function automatic logic [W-1:0] pick(input int i);
    logic [W-1:0] edges [16] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h07, 8'h7f, 8'h80,
                                 8'h81, 8'hfe, 8'hff, 8'h55, 8'haa, 8'h40, 8'h3c, 8'hc9};
    if (i < 16) return edges[i];
    return W'((i * 37 + 11) % 256);
  endfunction

  // start at a negedge; returns number of busy cycles observed
  task automatic runOp(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit poke, output int cyc);
    startValid = 1'b1; startOp = op; opA = a; opB = b;
    @(negedge clk);
    startValid = 1'b0;
    cyc = 0;
    while (busy) begin
      cyc++;
      if (poke && cyc == 3) begin
        startValid = 1'b1; startOp = ~op; opA = ~a; opB = b ^ 8'h3c;
      end else begin
        startValid = 1'b0;
      end
      @(negedge clk);
      if (cyc > 100) break;
    end
    startValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [W-1:0] eh, el, h0, l0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 hi", 32'(hiData), 0);
    chk("R1 lo", 32'(loData), 0);
    chk("R1 busy", 32'(busy), 0);

    // R8: read request coinciding with start, and with write-back
    readHiReq = 1'b1;
    startValid = 1'b1; startOp = 2'd1; opA = 8'hc8; opB = 8'h0f;
    #1 chk("R8 no stall idle", 32'(readStall), 0);
    @(negedge clk);
    startValid = 1'b0;
    chk("R8 stall busy", 32'(readStall), 1);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); if (cyc > 100) break; end
    model(2'd1, 8'hc8, 8'h0f, eh, el);
    chk("R8 stall cleared", 32'(readStall), 0);
    chk("R8 hi same cycle", 32'(hiData), 32'(eh));
    chk("R2 busy length", 32'(cyc), W + 1);
    readHiReq = 1'b0;
    readLoReq = 1'b1;
    #1 chk("R8 lo idle no stall", 32'(readStall), 0);
    readLoReq = 1'b0;

    // R7: start during busy is ignored
    runOp(2'd2, 8'h9c, 8'h07, 1'b1, cyc);
    model(2'd2, 8'h9c, 8'h07, eh, el);
    chk("R7 busy length", 32'(cyc), W + 1);
    chk("R7 hi", 32'(hiData), 32'(eh));
    chk("R7 lo", 32'(loData), 32'(el));
    chk("R7 idle after", 32'(busy), 0);

    // R10: idle hold while operands wiggle
    h0 = hiData; l0 = loData;
    for (int k = 0; k < 6; k++) begin
      opA = W'(k * 29); opB = W'(k * 71); startOp = 2'(k);
      @(negedge clk);
    end
    chk("R10 hi hold", 32'(hiData), 32'(h0));
    chk("R10 lo hold", 32'(loData), 32'(l0));

    // R6 corner: most negative / -1
    runOp(2'd2, 8'h80, 8'hff, 1'b0, cyc);
    chk("R6 minneg lo", 32'(loData), 32'h80);
    chk("R6 minneg hi", 32'(hiData), 32'h00);

    // sweep R3 R4 R5 R6 R9
    for (int i = 0; i < 28; i++) begin
      for (int j = 0; j < 28; j++) begin
        for (int op = 0; op < 4; op++) begin
          logic [W-1:0] a, b;
          string tag;
          a = pick(i); b = pick(j);
          runOp(2'(op), a, b, 1'b0, cyc);
          if (b == 0 && op >= 2) begin
            chk("R9 div0 busy length", 32'(cyc), W + 1);
          end else begin
            model(2'(op), a, b, eh, el);
            case (op)
              0: tag = "R4";
              1: tag = "R3";
              2: tag = "R6";
              default: tag = "R5";
            endcase
            chk($sformatf("%s busy op%0d a=%0h b=%0h", tag, op, a, b), 32'(cyc), W + 1);
            chk($sformatf("%s hi op%0d a=%0h b=%0h", tag, op, a, b), 32'(hiData), 32'(eh));
            chk($sformatf("%s lo op%0d a=%0h b=%0h", tag, op, a, b), 32'(loData), 32'(el));
          end
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule